// File: doc/BRIEF.md
# Superpage-Aware Translation Lookaside Buffer

This block is a small fully associative address translation cache for a three-level, 39-bit virtual address scheme. Each entry maps a 27-bit virtual page number to a 44-bit physical page number. An entry covers a 4 KB page, a 2 MB superpage or a 1 GB superpage. Each entry also holds the page-table permission bits, a cached page-fault marker and the memory attribute bits that the refill source supplies. The block accepts one request per cycle, made of a virtual address and a 3-bit access command. One cycle later it returns the physical address, a miss flag, and separate page-fault and access-fault flags for load, store and instruction fetch.

Entries are written through a refill port into a round-robin victim slot, and a flush input invalidates every entry at once. The page-table walk that produces the refill data is outside the block. So is the lookup that produces the memory attributes. Any miss is reported to the requester, which must supply the refill.

Top module: `vxl_tlb`

## Requirements
- R1: A request presented with `req_valid` high at a clock edge produces `rsp_valid` high after that edge. A cycle with no request leaves `rsp_valid` low after the edge, with `rsp_paddr`, `rsp_miss`, `rsp_perm`, `rsp_attr` and all six fault flags at zero.
- R2: The access class is decoded from `req_cmd[1:0]` only: 00 is load, 01 is store, 10 is fetch, and 11 is no access class, which raises no fault flag. `req_cmd[2]` marks an atomic access and does not change the class, so 100 is an atomic load, 101 is an atomic store and 110 is a plain fetch.
- R3: An entry refilled with `fill_level` = 2 is a 4 KB entry. It hits only when all three 9-bit VPN fields match. On a hit the physical page number is the stored PPN, and `rsp_perm` and `rsp_attr` return that entry's stored bits.
- R4: An entry refilled with `fill_level` = 1 is a 2 MB superpage. It hits when VPN bits [26:18] and [17:9] match, whatever bits [8:0] hold. The physical page number is stored PPN bits [43:9] followed by request VPN bits [8:0].
- R5: An entry refilled with `fill_level` = 0 is a 1 GB superpage. It hits when VPN bits [26:18] match. The physical page number is stored PPN bits [43:18] followed by request VPN bits [17:0].
- R6: On a miss, `rsp_miss` is 1, `rsp_paddr`, `rsp_perm` and `rsp_attr` are 0, and no fault flag is raised.
- R7: A hit on an entry refilled with `fill_pf` = 1 raises the page-fault flag of the requested access class, whatever its permission bits hold.
- R8: On a hit, the permission bits (`fill_perm` bit 0 r, 1 w, 2 x, 3 u, 4 g, 5 a, 6 d) raise page faults as follows. A load faults when r or a is clear. A store faults when w, a or d is clear. A fetch faults when x is clear.
- R9: On a hit, the attribute bits (`fill_attr` bit 0 readable, 1 writable, 2 executable, 3 atomic-permitted, 4 instruction-cacheable, 5 data-cacheable) raise access faults, independently of page faults. A load needs readable and a store needs writable. An atomic load or store also needs atomic-permitted. A fetch needs executable.
- R10: Refills fill slots in round-robin order starting at slot 0 after reset. With ENTRIES slots, refill number ENTRIES+1 overwrites the entry written by the first refill, and the other entries stay intact.
- R11: Flush invalidates every entry at the clock edge where it is presented, so a request in the following cycle misses. A refill presented in the same cycle as a flush is dropped.
- R12: On every hit, the low 12 bits of `rsp_paddr` equal the low 12 bits of the request's virtual address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 39 | Virtual address |
| req_cmd | input | 3 | Access command: class in bits 1:0, atomic in bit 2 |
| fill_valid | input | 1 | Write an entry into the victim slot |
| fill_vpn | input | 27 | Virtual page number of the new entry |
| fill_ppn | input | 44 | Physical page number of the new entry |
| fill_level | input | 2 | 0 = 1 GB, 1 = 2 MB, 2 = 4 KB |
| fill_perm | input | 7 | Permission bits d a g u x w r (bit 6 down to 0) |
| fill_pf | input | 1 | Cached page-fault marker |
| fill_attr | input | 6 | Memory attribute bits |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 56 | Physical address |
| rsp_miss | output | 1 | No entry matched |
| rsp_pf_ld | output | 1 | Load page fault |
| rsp_pf_st | output | 1 | Store page fault |
| rsp_pf_if | output | 1 | Fetch page fault |
| rsp_af_ld | output | 1 | Load access fault |
| rsp_af_st | output | 1 | Store access fault |
| rsp_af_if | output | 1 | Fetch access fault |
| rsp_perm | output | 7 | Permission bits of the matching entry |
| rsp_attr | output | 6 | Attribute bits of the matching entry |

## Verification
Every response field is registered once, so the answer to a request seen at one rising edge is due right after that edge and holds until the next. Refill and flush also act at the edge where they are presented, so the earliest request that sees their effect is the one in the following cycle. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and reads the response on the next falling edge. Each lookup is therefore judged against the table contents written before its own cycle.

// File: rtl/vxl_tlb_pkg.sv
package vxl_tlb_pkg;

   // permission bit positions inside an entry's perm field
   localparam int PERM_W = 7;
   localparam int P_R = 0;
   localparam int P_W = 1;
   localparam int P_X = 2;
   localparam int P_A = 5;
   localparam int P_D = 6;

   // memory attribute bit positions
   localparam int ATTR_W = 6;
   localparam int M_RD  = 0;
   localparam int M_WR  = 1;
   localparam int M_EX  = 2;
   localparam int M_AMO = 3;

   // page size encoded by the level field
   localparam logic [1:0] LVL_1G = 2'd0;
   localparam logic [1:0] LVL_2M = 2'd1;

   typedef enum logic [1:0] {
      ACC_LD   = 2'b00,
      ACC_ST   = 2'b01,
      ACC_IF   = 2'b10,
      ACC_NONE = 2'b11
   } acc_e;

endpackage

// File: rtl/vxl_tlb_slot.sv
module vxl_tlb_slot
   import vxl_tlb_pkg::*;
#(
   parameter int SEG_W = 9,
   parameter int PPN_W = 44,
   localparam int VPN_W = 3 * SEG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [PPN_W-1:0]  wr_ppn,
   input  logic [1:0]        wr_lvl,
   input  logic [PERM_W-1:0] wr_perm,
   input  logic              wr_pf,
   input  logic [ATTR_W-1:0] wr_attr,
   input  logic [VPN_W-1:0]  lk_vpn,
   output logic              hit,
   output logic [PPN_W-1:0]  out_ppn,
   output logic [PERM_W-1:0] out_perm,
   output logic              out_pf,
   output logic [ATTR_W-1:0] out_attr
);

   logic              vld_q;
   logic [VPN_W-1:0]  tag_q;
   logic [PPN_W-1:0]  ppn_q;
   logic [1:0]        lvl_q;
   logic [PERM_W-1:0] perm_q;
   logic              pf_q;
   logic [ATTR_W-1:0] attr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vld_q <= 1'b0;
      else if (flush)  vld_q <= 1'b0;
      else if (wr_en)  vld_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q  <= wr_vpn;
         ppn_q  <= wr_ppn;
         lvl_q  <= wr_lvl;
         perm_q <= wr_perm;
         pf_q   <= wr_pf;
         attr_q <= wr_attr;
      end
   end

   logic top_eq, mid_eq, low_eq;
   assign top_eq = tag_q[3*SEG_W-1:2*SEG_W] == lk_vpn[3*SEG_W-1:2*SEG_W];
   assign mid_eq = tag_q[2*SEG_W-1:SEG_W]   == lk_vpn[2*SEG_W-1:SEG_W];
   assign low_eq = tag_q[SEG_W-1:0]         == lk_vpn[SEG_W-1:0];

   // level 0 needs the top field, level 1 adds the middle one, larger levels need all three
   assign hit = vld_q && top_eq
                && ((lvl_q == LVL_1G) || mid_eq)
                && ((lvl_q <= LVL_2M) || low_eq);

   always_comb begin
      case (lvl_q)
         LVL_1G:  out_ppn = {ppn_q[PPN_W-1:2*SEG_W], lk_vpn[2*SEG_W-1:0]};
         LVL_2M:  out_ppn = {ppn_q[PPN_W-1:SEG_W],   lk_vpn[SEG_W-1:0]};
         default: out_ppn = ppn_q;
      endcase
   end

   assign out_perm = perm_q;
   assign out_pf   = pf_q;
   assign out_attr = attr_q;

endmodule

// File: rtl/vxl_tlb_rr.sv
module vxl_tlb_rr #(
   parameter int ENTRIES = 8,
   localparam int IW = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               fill,
   output logic [ENTRIES-1:0] wr_sel
);

   logic [IW-1:0] ptr_q;
   logic          go;

   assign go = fill && !flush;

   generate
      if ((1 << IW) == ENTRIES) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  ptr_q <= '0;
            else if (go) ptr_q <= ptr_q + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  ptr_q <= '0;
            else if (go) ptr_q <= (ptr_q == IW'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
         end
      end
   endgenerate

   always_comb begin
      wr_sel = '0;
      if (go) wr_sel[ptr_q] = 1'b1;
   end

endmodule

// File: rtl/vxl_tlb_guard.sv
module vxl_tlb_guard
   import vxl_tlb_pkg::*;
(
   input  logic [2:0] cmd,
   input  logic       hit,
   input  logic       pf_mark,
   input  logic       p_r,
   input  logic       p_w,
   input  logic       p_x,
   input  logic       p_a,
   input  logic       p_d,
   input  logic       m_rd,
   input  logic       m_wr,
   input  logic       m_ex,
   input  logic       m_amo,
   output logic       pf_ld,
   output logic       pf_st,
   output logic       pf_if,
   output logic       af_ld,
   output logic       af_st,
   output logic       af_if
);

   acc_e cls;
   logic is_ld, is_st, is_if, atom;

   assign cls   = acc_e'(cmd[1:0]);
   assign atom  = cmd[2];
   assign is_ld = hit && (cls == ACC_LD);
   assign is_st = hit && (cls == ACC_ST);
   assign is_if = hit && (cls == ACC_IF);

   assign pf_ld = is_ld && (pf_mark || !p_r || !p_a);
   assign pf_st = is_st && (pf_mark || !p_w || !p_a || !p_d);
   assign pf_if = is_if && (pf_mark || !p_x);

   assign af_ld = is_ld && (!m_rd || (atom && !m_amo));
   assign af_st = is_st && (!m_wr || (atom && !m_amo));
   assign af_if = is_if && !m_ex;

endmodule

// File: rtl/vxl_tlb.sv
module vxl_tlb
   import vxl_tlb_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int SEG_W   = 9,
   parameter int PPN_W   = 44,
   parameter int OFF_W   = 12
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic [3*SEG_W+OFF_W-1:0]      req_vaddr,
   input  logic [2:0]                    req_cmd,
   input  logic                          fill_valid,
   input  logic [3*SEG_W-1:0]            fill_vpn,
   input  logic [PPN_W-1:0]              fill_ppn,
   input  logic [1:0]                    fill_level,
   input  logic [6:0]                    fill_perm,
   input  logic                          fill_pf,
   input  logic [5:0]                    fill_attr,
   input  logic                          flush,
   output logic                          rsp_valid,
   output logic [PPN_W+OFF_W-1:0]        rsp_paddr,
   output logic                          rsp_miss,
   output logic                          rsp_pf_ld,
   output logic                          rsp_pf_st,
   output logic                          rsp_pf_if,
   output logic                          rsp_af_ld,
   output logic                          rsp_af_st,
   output logic                          rsp_af_if,
   output logic [6:0]                    rsp_perm,
   output logic [5:0]                    rsp_attr
);

   localparam int VPN_W = 3 * SEG_W;
   localparam int VA_W  = VPN_W + OFF_W;
   localparam int PA_W  = PPN_W + OFF_W;

   generate
      if (ENTRIES < 2) begin : g_bad_entries
         $error("vxl_tlb: ENTRIES must be at least 2");
      end
      if (PPN_W < 2 * SEG_W + 1) begin : g_bad_ppn
         $error("vxl_tlb: PPN_W must exceed two VPN fields");
      end
      if (PERM_W != 7 || ATTR_W != 6) begin : g_bad_pkg
         $error("vxl_tlb: package field widths do not match the ports");
      end
   endgenerate

   logic [VPN_W-1:0]  lk_vpn;
   logic [ENTRIES-1:0] wr_sel;
   logic [ENTRIES-1:0] hit_v;
   logic [PPN_W-1:0]  s_ppn  [ENTRIES];
   logic [PERM_W-1:0] s_perm [ENTRIES];
   logic              s_pf   [ENTRIES];
   logic [ATTR_W-1:0] s_attr [ENTRIES];

   assign lk_vpn = req_vaddr[VA_W-1:OFF_W];

   vxl_tlb_rr #(.ENTRIES(ENTRIES)) u_rr (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (flush),
      .fill   (fill_valid),
      .wr_sel (wr_sel)
   );

   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
         vxl_tlb_slot #(.SEG_W(SEG_W), .PPN_W(PPN_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .wr_en    (wr_sel[i]),
            .wr_vpn   (fill_vpn),
            .wr_ppn   (fill_ppn),
            .wr_lvl   (fill_level),
            .wr_perm  (fill_perm),
            .wr_pf    (fill_pf),
            .wr_attr  (fill_attr),
            .lk_vpn   (lk_vpn),
            .hit      (hit_v[i]),
            .out_ppn  (s_ppn[i]),
            .out_perm (s_perm[i]),
            .out_pf   (s_pf[i]),
            .out_attr (s_attr[i])
         );
      end
   endgenerate

   // lowest-numbered matching slot wins
   logic              any_hit;
   logic [PPN_W-1:0]  sel_ppn;
   logic [PERM_W-1:0] sel_perm;
   logic              sel_pf;
   logic [ATTR_W-1:0] sel_attr;

   always_comb begin
      any_hit  = 1'b0;
      sel_ppn  = '0;
      sel_perm = '0;
      sel_pf   = 1'b0;
      sel_attr = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_v[i] && !any_hit) begin
            any_hit  = 1'b1;
            sel_ppn  = s_ppn[i];
            sel_perm = s_perm[i];
            sel_pf   = s_pf[i];
            sel_attr = s_attr[i];
         end
      end
   end

   logic g_pf_ld, g_pf_st, g_pf_if, g_af_ld, g_af_st, g_af_if;

   vxl_tlb_guard u_guard (
      .cmd     (req_cmd),
      .hit     (req_valid && any_hit),
      .pf_mark (sel_pf),
      .p_r     (sel_perm[P_R]),
      .p_w     (sel_perm[P_W]),
      .p_x     (sel_perm[P_X]),
      .p_a     (sel_perm[P_A]),
      .p_d     (sel_perm[P_D]),
      .m_rd    (sel_attr[M_RD]),
      .m_wr    (sel_attr[M_WR]),
      .m_ex    (sel_attr[M_EX]),
      .m_amo   (sel_attr[M_AMO]),
      .pf_ld   (g_pf_ld),
      .pf_st   (g_pf_st),
      .pf_if   (g_pf_if),
      .af_ld   (g_af_ld),
      .af_st   (g_af_st),
      .af_if   (g_af_if)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_paddr <= '0;
         rsp_miss  <= 1'b0;
         rsp_pf_ld <= 1'b0;
         rsp_pf_st <= 1'b0;
         rsp_pf_if <= 1'b0;
         rsp_af_ld <= 1'b0;
         rsp_af_st <= 1'b0;
         rsp_af_if <= 1'b0;
         rsp_perm  <= '0;
         rsp_attr  <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_miss  <= req_valid && !any_hit;
         rsp_pf_ld <= g_pf_ld;
         rsp_pf_st <= g_pf_st;
         rsp_pf_if <= g_pf_if;
         rsp_af_ld <= g_af_ld;
         rsp_af_st <= g_af_st;
         rsp_af_if <= g_af_if;
         if (req_valid && any_hit) begin
            rsp_paddr <= PA_W'({sel_ppn, req_vaddr[OFF_W-1:0]});
            rsp_perm  <= sel_perm;
            rsp_attr  <= sel_attr;
         end else begin
            rsp_paddr <= '0;
            rsp_perm  <= '0;
            rsp_attr  <= '0;
         end
      end
   end

endmodule

// File: rtl/vxl_tlb_chk.sv
module vxl_tlb_chk #(
   parameter int SEG_W = 9,
   parameter int PPN_W = 44,
   parameter int OFF_W = 12
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     req_valid,
   input logic [3*SEG_W+OFF_W-1:0] req_vaddr,
   input logic                     flush,
   input logic                     rsp_valid,
   input logic [PPN_W+OFF_W-1:0]   rsp_paddr,
   input logic                     rsp_miss,
   input logic                     rsp_pf_ld,
   input logic                     rsp_pf_st,
   input logic                     rsp_pf_if,
   input logic                     rsp_af_ld,
   input logic                     rsp_af_st,
   input logic                     rsp_af_if
);

   // R1
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R1
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_miss && rsp_paddr == '0));

   // R6
   miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> (rsp_paddr == '0 && !rsp_pf_ld && !rsp_pf_st && !rsp_pf_if
                    && !rsp_af_ld && !rsp_af_st && !rsp_af_if));

   // R12
   offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_miss || rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

   // R2
   single_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_pf_ld | rsp_af_ld, rsp_pf_st | rsp_af_st, rsp_pf_if | rsp_af_if}));

   // R11
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush ##1 req_valid |=> rsp_miss);

endmodule

bind vxl_tlb vxl_tlb_chk #(.SEG_W(SEG_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) u_vxl_tlb_chk (.*);

// File: tb/tb_vxl_tlb.sv
`timescale 1ns/1ps
module tb_vxl_tlb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [38:0] req_vaddr = '0;
   logic [2:0]  req_cmd = '0;
   logic        fill_valid = 1'b0;
   logic [26:0] fill_vpn = '0;
   logic [43:0] fill_ppn = '0;
   logic [1:0]  fill_level = '0;
   logic [6:0]  fill_perm = '0;
   logic        fill_pf = 1'b0;
   logic [5:0]  fill_attr = '0;
   logic        flush = 1'b0;
   logic        rsp_valid;
   logic [55:0] rsp_paddr;
   logic        rsp_miss;
   logic        rsp_pf_ld, rsp_pf_st, rsp_pf_if;
   logic        rsp_af_ld, rsp_af_st, rsp_af_if;
   logic [6:0]  rsp_perm;
   logic [5:0]  rsp_attr;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   vxl_tlb dut (.*);

   typedef struct packed {
      logic [38:0] va;
      logic [2:0]  cmd;
      logic        miss;
      logic [43:0] ppn;
      logic [2:0]  pf;   // {ld, st, if}
      logic [2:0]  af;   // {ld, st, if}
   } vec_t;

   localparam int NV = 21;
   localparam vec_t TBL [NV] = '{
      '{{9'd1, 9'd2, 9'd3, 12'hABC},     3'b000, 1'b0, 44'h100,   3'b000, 3'b000}, // R3 load
      '{{9'd1, 9'd2, 9'd3, 12'hABC},     3'b001, 1'b0, 44'h100,   3'b000, 3'b000}, // R3 store
      '{{9'd1, 9'd2, 9'd3, 12'hABC},     3'b010, 1'b0, 44'h100,   3'b000, 3'b000}, // R3 fetch
      '{{9'd1, 9'd2, 9'd3, 12'h001},     3'b011, 1'b0, 44'h100,   3'b000, 3'b000}, // R2 no class
      '{{9'd4, 9'd5, 9'h1FF, 12'h123},   3'b000, 1'b0, 44'h5FF,   3'b000, 3'b000}, // R4 2MB hit
      '{{9'd4, 9'd6, 9'd0, 12'h000},     3'b000, 1'b1, 44'h0,     3'b000, 3'b000}, // R4 mid mismatch
      '{{9'd6, 9'h155, 9'h0AA, 12'h007}, 3'b010, 1'b0, 44'hAAAAA, 3'b000, 3'b000}, // R5 1GB hit
      '{{9'd7, 9'd0, 9'd0, 12'h000},     3'b000, 1'b1, 44'h0,     3'b000, 3'b000}, // R5 top mismatch
      '{{9'd1, 9'd2, 9'd8, 12'h000},     3'b000, 1'b1, 44'h0,     3'b000, 3'b000}, // R3 low mismatch, R6
      '{{9'd1, 9'd2, 9'd4, 12'h010},     3'b000, 1'b0, 44'h300,   3'b000, 3'b000}, // R8 load allowed
      '{{9'd1, 9'd2, 9'd4, 12'h010},     3'b001, 1'b0, 44'h300,   3'b010, 3'b010}, // R8 R9 store
      '{{9'd1, 9'd2, 9'd4, 12'h010},     3'b010, 1'b0, 44'h300,   3'b001, 3'b001}, // R8 R9 fetch
      '{{9'd1, 9'd2, 9'd5, 12'h020},     3'b000, 1'b0, 44'h500,   3'b100, 3'b000}, // R7 load
      '{{9'd1, 9'd2, 9'd5, 12'h020},     3'b001, 1'b0, 44'h500,   3'b010, 3'b000}, // R7 store
      '{{9'd1, 9'd2, 9'd5, 12'h020},     3'b010, 1'b0, 44'h500,   3'b001, 3'b000}, // R7 fetch
      '{{9'd1, 9'd2, 9'd6, 12'h030},     3'b001, 1'b0, 44'h600,   3'b010, 3'b000}, // R8 dirty clear
      '{{9'd1, 9'd2, 9'd6, 12'h030},     3'b100, 1'b0, 44'h600,   3'b000, 3'b100}, // R9 atomic load
      '{{9'd1, 9'd2, 9'd6, 12'h030},     3'b101, 1'b0, 44'h600,   3'b010, 3'b010}, // R9 atomic store
      '{{9'd1, 9'd2, 9'd7, 12'h040},     3'b000, 1'b0, 44'h700,   3'b100, 3'b000}, // R8 read clear
      '{{9'd1, 9'd2, 9'd7, 12'h040},     3'b010, 1'b0, 44'h700,   3'b000, 3'b000}, // R8 fetch allowed
      '{{9'd1, 9'd2, 9'd3, 12'hFFF},     3'b110, 1'b0, 44'h100,   3'b000, 3'b000}  // R2 bit2 with fetch
   };

   task automatic check_eq(input string tag, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   task automatic refill(input logic [26:0] vpn, input logic [43:0] ppn,
                         input logic [1:0] lvl, input logic [6:0] perm,
                         input logic pf, input logic [5:0] attr, input logic fl);
      @(negedge clk);
      fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_level = lvl;
      fill_perm = perm; fill_pf = pf; fill_attr = attr; flush = fl;
      @(negedge clk);
      fill_valid = 1'b0; flush = 1'b0;
   endtask

   // one request; response read one falling edge later, after exactly one rising edge
   task automatic lookup(input logic [38:0] va, input logic [2:0] cmd);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_cmd = cmd;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   function automatic logic [63:0] pack_rsp();
      return {rsp_valid, rsp_paddr, rsp_miss,
              rsp_pf_ld, rsp_pf_st, rsp_pf_if, rsp_af_ld, rsp_af_st, rsp_af_if};
   endfunction

   function automatic logic [63:0] pack_exp(input logic miss, input logic [43:0] ppn,
                                            input logic [11:0] off,
                                            input logic [2:0] pf, input logic [2:0] af);
      return {1'b1, miss ? 56'h0 : {ppn, off}, miss, pf, af};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check_eq("R1", "reset outputs", {pack_rsp(), 8'h0},
               {1'b0, 56'h0, 1'b0, 6'h0, 8'h0});
      rst_n = 1'b1;

      // R6 empty table misses
      lookup({9'd1, 9'd2, 9'd3, 12'h5A5}, 3'b000);
      check_eq("R6", "miss after reset", pack_rsp(), pack_exp(1'b1, 44'h0, 12'h0, 3'b000, 3'b000));

      // slots 0..6 loaded in order
      refill({9'd1, 9'd2, 9'd3}, 44'h100,   2'd2, 7'h67, 1'b0, 6'h3F, 1'b0);
      refill({9'd4, 9'd5, 9'd0}, 44'h400,   2'd1, 7'h67, 1'b0, 6'h3F, 1'b0);
      refill({9'd6, 9'd0, 9'd0}, 44'h80000, 2'd0, 7'h67, 1'b0, 6'h3F, 1'b0);
      refill({9'd1, 9'd2, 9'd4}, 44'h300,   2'd2, 7'h21, 1'b0, 6'h01, 1'b0);
      refill({9'd1, 9'd2, 9'd5}, 44'h500,   2'd2, 7'h67, 1'b1, 6'h3F, 1'b0);
      refill({9'd1, 9'd2, 9'd6}, 44'h600,   2'd2, 7'h27, 1'b0, 6'h37, 1'b0);
      refill({9'd1, 9'd2, 9'd7}, 44'h700,   2'd2, 7'h24, 1'b0, 6'h3F, 1'b0);

      for (int i = 0; i < NV; i++) begin
         lookup(TBL[i].va, TBL[i].cmd);
         check_eq($sformatf("R-vec%0d", i), "table response", pack_rsp(),
                  pack_exp(TBL[i].miss, TBL[i].ppn, TBL[i].va[11:0], TBL[i].pf, TBL[i].af));
      end

      // R3 stored perm and attr returned on hit
      lookup({9'd1, 9'd2, 9'd4, 12'h0}, 3'b000);
      check_eq("R3", "perm/attr", {51'h0, rsp_perm, rsp_attr}, {51'h0, 7'h21, 6'h01});

      // R1 idle cycle clears the response
      @(negedge clk);
      check_eq("R1", "idle response", {pack_rsp(), 8'h0}, {1'b0, 56'h0, 1'b0, 6'h0, 8'h0});

      // R10 slot 7 then wrap to slot 0
      refill({9'd7, 9'd7, 9'd7}, 44'h777, 2'd2, 7'h67, 1'b0, 6'h3F, 1'b0);
      refill({9'd8, 9'd8, 9'd8}, 44'h888, 2'd2, 7'h67, 1'b0, 6'h3F, 1'b0);
      lookup({9'd1, 9'd2, 9'd3, 12'h0}, 3'b000);
      check_eq("R10", "oldest evicted", pack_rsp(), pack_exp(1'b1, 44'h0, 12'h0, 3'b000, 3'b000));
      lookup({9'd8, 9'd8, 9'd8, 12'h44}, 3'b000);
      check_eq("R10", "new entry hits", pack_rsp(), pack_exp(1'b0, 44'h888, 12'h44, 3'b000, 3'b000));
      lookup({9'd4, 9'd5, 9'd1, 12'h0}, 3'b000);
      check_eq("R10", "neighbour kept", pack_rsp(), pack_exp(1'b0, 44'h401, 12'h0, 3'b000, 3'b000));
      lookup({9'd7, 9'd7, 9'd7, 12'h9}, 3'b001);
      check_eq("R10", "slot 7 kept", pack_rsp(), pack_exp(1'b0, 44'h777, 12'h9, 3'b000, 3'b000));

      // R11 flush with a simultaneous refill
      refill({9'd9, 9'd9, 9'd9}, 44'h999, 2'd2, 7'h67, 1'b0, 6'h3F, 1'b1);
      lookup({9'd4, 9'd5, 9'd1, 12'h0}, 3'b000);
      check_eq("R11", "flushed entry", pack_rsp(), pack_exp(1'b1, 44'h0, 12'h0, 3'b000, 3'b000));
      lookup({9'd9, 9'd9, 9'd9, 12'h0}, 3'b000);
      check_eq("R11", "refill dropped", pack_rsp(), pack_exp(1'b1, 44'h0, 12'h0, 3'b000, 3'b000));
      lookup({9'd8, 9'd8, 9'd8, 12'h0}, 3'b000);
      check_eq("R11", "all invalid", pack_rsp(), pack_exp(1'b1, 44'h0, 12'h0, 3'b000, 3'b000));

      // R12 refill after flush works, offset preserved
      refill({9'd3, 9'd3, 9'd3}, 44'hABC00, 2'd1, 7'h67, 1'b0, 6'h3F, 1'b0);
      lookup({9'd3, 9'd3, 9'd5, 12'h7E1}, 3'b000);
      check_eq("R12", "offset through", pack_rsp(), pack_exp(1'b0, 44'hABC05, 12'h7E1, 3'b000, 3'b000));

      @(negedge clk);
      finish_run();
   end

endmodule